// File: doc/BRIEF.md
# Memory-Reading Ones-Complement Checksum Engine

This block computes the 16-bit ones-complement sum that TCP/IP uses for its checksums, over a payload that already sits in shared data memory. Software writes a word-aligned start address and a byte count into the block's registers, then sets a start bit. From there the engine fetches the payload itself through a read-master port. It folds each 32-bit word into a wide accumulator as two 16-bit halfwords. When the payload is used up, it reduces the end-around carries and publishes the result in a readable register, with a done flag.

The read port reaches the shared SRAM through an external arbiter that may stall it. The engine therefore holds each request, with its address, until the arbiter accepts it. Only one accepted read is ever waiting for its data. When the memory is free, a new request is accepted on every cycle, so a full-size packet finishes in a few hundred cycles. An optional control bit makes the result register hold the complemented sum, which is the value that goes into a header.

Top module: `cksum_engine`

## Requirements
- R1: After reset, every register reads as zero. The registers are: base address at index 0, length at index 1, control at index 2, status at index 3, result at index 4. Read data appears on `s_rdata` in the cycle after the cycle in which `s_rd` is sampled.
- R2: The result is the 16-bit ones-complement sum of the payload's halfwords. Within a word, byte k (the byte at word address + k) is `m_rdata[8k+7:8k]`. Each halfword takes the byte at the lower address as its high-order byte.
- R3: When the length is odd, the last byte is paired with a zero low-order byte. In a trailing partial word, only the bytes inside the length contribute.
- R4: All end-around carries are folded back into the low 16 bits before the result is published. For example, a payload of all-ones halfwords gives 0xFFFF.
- R5: If control bit 1 is set together with the start bit, the result register holds the bitwise complement of the folded sum. Otherwise it holds the sum itself.
- R6: While the engine is busy, a start write or a write to the base or length register has no effect. The running job completes with its own address and length, and no second job is run.
- R7: Status bit 0 is busy and status bit 1 is done. An accepted start sets busy and clears done. Publishing the result clears busy and sets done. The two bits are never set together.
- R8: A length of zero completes with done set, a raw result of zero, and no memory read.
- R9: While `m_read` is high and `m_wait` is high, `m_read` stays high and `m_addr` stays unchanged in the next cycle.
- R10: The first read goes to the base address, and each accepted read advances the address by 4. Exactly ceil(length/4) reads are accepted. At most one accepted read is ever awaiting its data, which arrives with `m_rvalid` in the cycle after acceptance.
- R11: With no wait states, a 1300-byte payload reaches done within 386 cycles of the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | 3 | Register index for CPU accesses |
| s_wr | input | 1 | CPU register write strobe |
| s_wdata | input | 32 | CPU write data |
| s_rd | input | 1 | CPU register read strobe |
| s_rdata | output | 32 | Registered CPU read data |
| m_addr | output | ADDR_W | Byte address of the current memory read |
| m_read | output | 1 | Memory read request, held until accepted |
| m_wait | input | 1 | Arbiter stall; the request is accepted in a cycle where it is low |
| m_rvalid | input | 1 | Read data valid, one cycle after acceptance |
| m_rdata | input | 32 | Read data from memory |

## Verification
The embedded assertions watch the bus contract on every cycle. A stalled request must keep its address, consecutive accepted reads must step by 4, no more than one accepted read may await its data, and a read is never issued beyond the word count. They also check that a start reaches the sequencer only while it is idle, that busy and done are never set together, that each result is published only once, and that the accumulator never overflows. The arithmetic itself needs the bench's scenarios. These cover halfword pairing and byte order, odd and partial tails, carry folding on all-ones data, and the complemented result. They also cover the zero-length case, the cycle bound on a full packet, and whether a start or a register write during a running job is truly ignored. The bench judges all of these against its own reference sum and its own count of accepted read addresses.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  localparam int WORD_W         = 32;
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int SUM_W          = 16;
  localparam int REG_IDX_W      = 3;

  localparam logic [REG_IDX_W-1:0] REG_BASE   = 3'd0;
  localparam logic [REG_IDX_W-1:0] REG_LEN    = 3'd1;
  localparam logic [REG_IDX_W-1:0] REG_CTRL   = 3'd2;
  localparam logic [REG_IDX_W-1:0] REG_STAT   = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_RESULT = 3'd4;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_INV_BIT  = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/cksum_regs.sv
module cksum_regs
  import cksum_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_IDX_W-1:0] s_addr,
  input  logic                 s_wr,
  input  logic [WORD_W-1:0]    s_wdata,
  input  logic                 s_rd,
  output logic [WORD_W-1:0]    s_rdata,
  output logic [ADDR_W-1:0]    base_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 start_o,
  input  logic                 sum_vld_i,
  input  logic [SUM_W-1:0]     sum_i
);
  logic             busy_q, done_q, inv_q;
  logic [SUM_W-1:0] result_q;
  logic [WORD_W-1:0] rd_mux;
  logic              wdata_unused;

  assign wdata_unused = ^s_wdata;

  always_comb begin
    rd_mux = '0;
    case (s_addr)
      REG_BASE:   rd_mux = WORD_W'(base_o);
      REG_LEN:    rd_mux = WORD_W'(len_o);
      REG_CTRL:   rd_mux[CTRL_INV_BIT] = inv_q;
      REG_STAT: begin
        rd_mux[STAT_BUSY_BIT] = busy_q;
        rd_mux[STAT_DONE_BIT] = done_q;
      end
      REG_RESULT: rd_mux = WORD_W'(result_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o   <= '0;
      len_o    <= '0;
      start_o  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      inv_q    <= 1'b0;
      result_q <= '0;
      s_rdata  <= '0;
    end else begin
      start_o <= 1'b0;
      if (s_wr && !busy_q) begin
        case (s_addr)
          REG_BASE: base_o <= {s_wdata[ADDR_W-1:2], 2'b00};
          REG_LEN:  len_o  <= s_wdata[LEN_W-1:0];
          REG_CTRL: begin
            if (s_wdata[CTRL_GO_BIT]) begin
              busy_q  <= 1'b1;
              done_q  <= 1'b0;
              start_o <= 1'b1;
              inv_q   <= s_wdata[CTRL_INV_BIT];
            end
          end
          default: ;
        endcase
      end
      if (sum_vld_i) begin
        result_q <= inv_q ? ~sum_i : sum_i;
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
      end
      if (s_rd) s_rdata <= rd_mux;
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)); // R7
  AST_RESULT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    sum_vld_i |-> busy_q); // R7
  AST_IDLE_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_o) |=> $stable(result_q)); // R6
endmodule

// File: rtl/cksum_fetch.sv
module cksum_fetch
  import cksum_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_read,
  input  logic              m_wait,
  input  logic              m_rvalid,
  input  logic [WORD_W-1:0] m_rdata,
  output logic [WORD_W-1:0] word_o,
  output logic [2:0]        nbytes_o,
  output logic              word_vld_o,
  output logic              finish_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] words;
  logic [CNT_W-1:0] issue_left, recv_left;
  logic [2:0]       last_n;
  logic             active;

  assign words = ({1'b0, len_i} + CNT_W'(BYTES_PER_WORD - 1)) >> 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_addr     <= '0;
      m_read     <= 1'b0;
      issue_left <= '0;
      recv_left  <= '0;
      last_n     <= 3'd0;
      active     <= 1'b0;
      word_o     <= '0;
      nbytes_o   <= 3'd0;
      word_vld_o <= 1'b0;
      finish_o   <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      finish_o   <= 1'b0;
      if (start_i) begin
        m_addr     <= base_i;
        issue_left <= words;
        recv_left  <= words;
        m_read     <= (words != '0);
        last_n     <= (len_i[1:0] == 2'd0) ? 3'd4 : {1'b0, len_i[1:0]};
        if (words == '0) finish_o <= 1'b1;
        else             active   <= 1'b1;
      end else begin
        if (m_read && !m_wait) begin
          m_addr     <= m_addr + ADDR_W'(BYTES_PER_WORD);
          issue_left <= issue_left - 1'b1;
          m_read     <= (issue_left != CNT_W'(1));
        end
        if (active && m_rvalid) begin
          word_o     <= m_rdata;
          nbytes_o   <= (recv_left == CNT_W'(1)) ? last_n : 3'd4;
          word_vld_o <= 1'b1;
          recv_left  <= recv_left - 1'b1;
          if (recv_left == CNT_W'(1)) begin
            active   <= 1'b0;
            finish_o <= 1'b1;
          end
        end
      end
    end
  end

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (m_read && m_wait) |=> (m_read && $stable(m_addr))); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (m_read && !m_wait && !start_i) |=> (m_addr == $past(m_addr) + ADDR_W'(4))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (recv_left - issue_left) <= CNT_W'(1)); // R10
  AST_NO_EXTRA_READ: assert property (@(posedge clk) disable iff (rst)
    m_read |-> (issue_left != '0)); // R10
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (!active && !m_read)); // R6
endmodule

// File: rtl/cksum_accum.sv
module cksum_accum
  import cksum_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        nbytes_i,
  input  logic              finish_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              sum_vld_o
);
  localparam int ACC_W = LEN_W + 17;

  logic [ACC_W-1:0] acc_q;
  logic             folding;
  logic [7:0]       bytes [BYTES_PER_WORD];
  logic [SUM_W-1:0] half_hi, half_lo;

  for (genvar k = 0; k < BYTES_PER_WORD; k++) begin : g_mask
    assign bytes[k] = (3'(k) < nbytes_i) ? word_i[8*k +: 8] : 8'h00;
  end

  assign half_hi = {bytes[0], bytes[1]};
  assign half_lo = {bytes[2], bytes[3]};

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_q     <= '0;
      folding   <= 1'b0;
      sum_o     <= '0;
      sum_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= 1'b0;
      if (add_i) acc_q <= acc_q + ACC_W'(half_hi) + ACC_W'(half_lo);
      if (finish_i) folding <= 1'b1;
      if (folding) begin
        if (acc_q[ACC_W-1:SUM_W] == '0) begin
          sum_o     <= acc_q[SUM_W-1:0];
          sum_vld_o <= 1'b1;
          folding   <= 1'b0;
        end else begin
          acc_q <= ACC_W'(acc_q[SUM_W-1:0]) + (acc_q >> SUM_W);
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !acc_q[ACC_W-1]); // R2
  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (rst)
    sum_vld_o |=> !sum_vld_o); // R4
  AST_NO_ADD_WHILE_FOLD: assert property (@(posedge clk) disable iff (rst)
    folding |-> !add_i); // R4
endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
  import cksum_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_IDX_W-1:0] s_addr,
  input  logic                 s_wr,
  input  logic [WORD_W-1:0]    s_wdata,
  input  logic                 s_rd,
  output logic [WORD_W-1:0]    s_rdata,
  output logic [ADDR_W-1:0]    m_addr,
  output logic                 m_read,
  input  logic                 m_wait,
  input  logic                 m_rvalid,
  input  logic [WORD_W-1:0]    m_rdata
);
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len;
  logic              start;
  logic [WORD_W-1:0] word;
  logic [2:0]        nbytes;
  logic              word_vld, finish, sum_vld;
  logic [SUM_W-1:0]  sum;

  cksum_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata),
    .s_rd(s_rd), .s_rdata(s_rdata), .base_o(base), .len_o(len),
    .start_o(start), .sum_vld_i(sum_vld), .sum_i(sum)
  );

  cksum_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base), .len_i(len),
    .m_addr(m_addr), .m_read(m_read), .m_wait(m_wait), .m_rvalid(m_rvalid),
    .m_rdata(m_rdata), .word_o(word), .nbytes_o(nbytes),
    .word_vld_o(word_vld), .finish_o(finish)
  );

  cksum_accum #(.LEN_W(LEN_W)) u_accum (
    .clk(clk), .rst(rst), .clear_i(start), .add_i(word_vld), .word_i(word),
    .nbytes_i(nbytes), .finish_i(finish), .sum_o(sum), .sum_vld_o(sum_vld)
  );
endmodule

// File: tb/tb_cksum_engine.sv
module tb_cksum_engine;
  import cksum_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  s_addr = '0;
  logic        s_wr = 1'b0, s_rd = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic [15:0] m_addr;
  logic        m_read;
  logic        m_wait = 1'b0, m_rvalid = 1'b0;
  logic [31:0] m_rdata = '0;

  always #4 clk = ~clk;

  cksum_engine dut (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata),
    .s_rd(s_rd), .s_rdata(s_rdata), .m_addr(m_addr), .m_read(m_read),
    .m_wait(m_wait), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
  );

  logic [31:0] mem [512];
  int nchk = 0, nfail = 0, cyc = 0;
  int acc_cnt = 0, addr_err = 0, hold_err = 0;
  logic [15:0] exp_addr = '0, prev_addr = '0;
  logic prev_hold = 1'b0, wait_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // memory, arbiter stall and bus monitors
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (prev_hold && (!m_read || m_addr != prev_addr)) hold_err = hold_err + 1;
    prev_hold <= m_read && m_wait;
    prev_addr <= m_addr;
    if (m_read && !m_wait) begin
      acc_cnt = acc_cnt + 1;
      if (m_addr != exp_addr) addr_err = addr_err + 1;
      exp_addr = exp_addr + 16'd4;
    end
    m_rvalid <= m_read && !m_wait;
    m_rdata  <= mem[m_addr[10:2]];
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_wait   <= wait_en && lfsr[0];
  end

  function automatic logic [7:0] mbyte(int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 511];
    return w[8*(a % 4) +: 8];
  endfunction

  function automatic logic [15:0] ref_sum(int base, int len);
    logic [31:0] s;
    logic [7:0]  hi, lo;
    s = 0;
    for (int i = 0; i < len; i += 2) begin
      hi = mbyte(base + i);
      lo = (i + 1 < len) ? mbyte(base + i + 1) : 8'h00;
      s = s + {16'h0, hi, lo};
    end
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_wdata = d; s_wr = 1'b1;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    s_addr = a; s_rd = 1'b1;
    @(negedge clk);
    s_rd = 1'b0;
    d = s_rdata;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = 0;
    for (int n = 0; n < 20000; n++) begin
      rd(REG_STAT, st);
      if (st[STAT_DONE_BIT]) break;
    end
  endtask

  task automatic prep(input int base, input bit wen);
    wait_en = wen;
    exp_addr = base[15:0];
    acc_cnt = 0;
    addr_err = 0;
    hold_err = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // [33:18] base, [17:2] length, [1] complement, [0] wait states
  localparam logic [33:0] VEC [8] = '{
    {16'h0000, 16'd64,   1'b0, 1'b0},
    {16'h0100, 16'd63,   1'b0, 1'b1},
    {16'h0200, 16'd66,   1'b1, 1'b0},
    {16'h0304, 16'd1,    1'b0, 1'b1},
    {16'h0400, 16'd7,    1'b1, 1'b1},
    {16'h0780, 16'd32,   1'b0, 1'b0},
    {16'h0780, 16'd32,   1'b1, 1'b1},
    {16'h0010, 16'd1300, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", cyc, 0);
    summary();
  end

  initial begin
    logic [31:0] d, st;
    int t0;
    for (int i = 0; i < 512; i++) mem[i] = (i * 32'h0100_0193) ^ 32'hA5C3_5A3C;
    for (int i = 480; i < 488; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(REG_STAT, d);   check(d == 0, "R1 status after reset", d, 0);
    rd(REG_RESULT, d); check(d == 0, "R1 result after reset", d, 0);
    rd(REG_BASE, d);   check(d == 0, "R1 base after reset", d, 0);
    rd(REG_LEN, d);    check(d == 0, "R1 length after reset", d, 0);

    // vector table: R2 R3 R4 R5 R9 R10
    for (int i = 0; i < 8; i++) begin
      logic [33:0] v;
      logic [15:0] e;
      v = VEC[i];
      e = ref_sum(int'(v[33:18]), int'(v[17:2]));
      if (v[1]) e = ~e;
      prep(int'(v[33:18]), v[0]);
      wr(REG_BASE, {16'h0, v[33:18]});
      wr(REG_LEN, {16'h0, v[17:2]});
      wr(REG_CTRL, {30'h0, v[1], 1'b1});
      wait_done(st);
      check(st[1:0] == 2'b10, "R7 status after job", st, 32'h2);
      rd(REG_RESULT, d);
      check(d == {16'h0, e}, "R2 R3 R4 R5 result", d, {16'h0, e});
      check(acc_cnt == (int'(v[17:2]) + 3) / 4, "R10 read count", acc_cnt,
            (int'(v[17:2]) + 3) / 4);
      check(addr_err == 0, "R10 read addresses", addr_err, 0);
      check(hold_err == 0, "R9 request hold under wait", hold_err, 0);
    end

    // R4 all-ones payload folds to 0xFFFF (vector 5) checked explicitly
    prep(16'h0780, 1'b0);
    wr(REG_BASE, 32'h780); wr(REG_LEN, 32'd8); wr(REG_CTRL, 32'h1);
    wait_done(st); rd(REG_RESULT, d);
    check(d == 32'hFFFF, "R4 carry fold all ones", d, 32'hFFFF);

    // R11 throughput with no wait states
    prep(0, 1'b0);
    wr(REG_BASE, 32'h0); wr(REG_LEN, 32'd1300);
    t0 = cyc;
    wr(REG_CTRL, 32'h1);
    wait_done(st);
    check(cyc - t0 <= 386, "R11 cycles for 1300 bytes", cyc - t0, 386);
    rd(REG_RESULT, d);
    check(d == {16'h0, ref_sum(0, 1300)}, "R11 result", d, {16'h0, ref_sum(0, 1300)});

    // R7 start sets busy and clears done
    prep(16'h0100, 1'b0);
    wr(REG_BASE, 32'h100); wr(REG_LEN, 32'd400);
    wr(REG_CTRL, 32'h1);
    rd(REG_STAT, st);
    check(st[1:0] == 2'b01, "R7 busy set done cleared on start", st, 32'h1);
    wait_done(st);

    // R6 start and register writes while busy are ignored
    prep(16'h0040, 1'b1);
    wr(REG_BASE, 32'h40); wr(REG_LEN, 32'd1000);
    wr(REG_CTRL, 32'h1);
    wr(REG_LEN, 32'd8);
    wr(REG_BASE, 32'h700);
    wr(REG_CTRL, 32'h3);
    wait_done(st);
    rd(REG_RESULT, d);
    check(d == {16'h0, ref_sum(32'h40, 1000)}, "R6 result of first job", d,
          {16'h0, ref_sum(32'h40, 1000)});
    check(acc_cnt == 250, "R6 no second job read", acc_cnt, 250);
    rd(REG_LEN, d);
    check(d == 32'd1000, "R6 length write ignored", d, 32'd1000);

    // R8 zero length
    prep(16'h0200, 1'b0);
    wr(REG_BASE, 32'h200); wr(REG_LEN, 32'd0); wr(REG_CTRL, 32'h1);
    wait_done(st);
    check(st[1:0] == 2'b10, "R8 zero length done", st, 32'h2);
    rd(REG_RESULT, d);
    check(d == 0, "R8 zero length result", d, 0);
    check(acc_cnt == 0, "R8 zero length no read", acc_cnt, 0);

    summary();
  end
endmodule